// File: doc/BRIEF.md
# Fault-Tolerant Router Crossbar with Bypass Buses

This block is the switch traversal stage of a five-port mesh router that uses XY routing. Each output port has its own multiplexer that picks one of the five input flits, using a select value that the switch allocator supplies every cycle. Each output multiplexer also has a fault flag. When an output's multiplexer is flagged, the flit for that output does not go through the multiplexer. It reaches the output over one of three shared bypass buses:

- a horizontal bus, fed by the East or West input;
- a vertical bus, fed by the North or South input;
- a local bus, fed by the Local input.

Under XY routing a flit that arrived on the Y axis never turns back onto the X axis. For that reason the vertical bus has no wiring to the East or West outputs. A request that would need that path is reported as an illegal route and dropped. When East and West both need the horizontal bus in the same cycle, a two-way round-robin arbiter picks one of them. The same applies to North and South on the vertical bus. The losing input receives a stall indication that goes back to the allocator. The datapath holds no flits: whatever leaves the block in a cycle was presented to it in that same cycle. The only state is the preference bit of each shared-bus arbiter.

Top module: `noc_xbar_bypass`

## Requirements
- R1: Port index 0 is North, 1 is East, 2 is South, 3 is West and 4 is Local, on every per-port vector. Outputs respond to inputs within the same cycle, with no register on the flit path.
- R2: For an output whose fault flag is low, the output asserts valid exactly when all three of these hold:
  - its request bit is high;
  - its select value is below 5;
  - the selected input is valid.

  When valid, the output's flit equals the selected input's flit.
- R3: For an output whose fault flag is high, the flit from the selected input arrives over a bypass bus chosen by the input: East or West uses the horizontal bus, North or South uses the vertical bus, and Local uses the local bus. Outputs with a low fault flag are not affected by this.
- R4: With all five fault flags high, up to three flits (one per bus) reach distinct outputs in one cycle.
- R5: A North or South input selected by a faulty East or West output is flagged on that input's illegal-route bit. That output's valid stays low, and that input's stall bit stays low.
- R6: When East and West both need the horizontal bus, or North and South both need the vertical bus, exactly one input of the pair is served. The other input's stall bit is high and its target output's valid is low. The Local input never stalls.
- R7: Each shared bus alternates preference: after any cycle in which the bus is granted, the other input of the pair is preferred. An input that is alone in requesting is always served.
- R8: An output with its request bit low, with an invalid selected input, or with a select value of 5 to 7 asserts no valid, whether or not it is faulty.
- R9: Reset, active low and asynchronous, sets the horizontal bus to prefer East and the vertical bus to prefer North. While no output requests, all valid, stall and illegal-route bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the arbiter preference bits |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flit_i | input | 5 x FLIT_W | Input flits, indexed by port |
| valid_i | input | 5 | Input flit valid |
| out_req_i | input | 5 | Per-output request from the switch allocator |
| out_sel_i | input | 5 x 3 | Per-output input index |
| mux_fault_i | input | 5 | Per-output multiplexer fault flag |
| flit_o | output | 5 x FLIT_W | Output flits |
| valid_o | output | 5 | Output flit valid |
| stall_o | output | 5 | Per-input stall after losing bus arbitration |
| illegal_o | output | 5 | Per-input illegal-route drop flag |

## Verification
The assertions assume that the switch allocator assigns each input to at most one output per cycle. They also assume that the fault flags change only while no flit depends on them. The directed stimulus follows both rules: every scenario routes each input to at most one output, and fault flags are set together with the requests that they affect. The round-robin sequences start from reset, so the preference bits are known before each contended cycle.

// File: rtl/noc_xbar_pkg.sv
package noc_xbar_pkg;
  localparam int unsigned NP    = 5;
  localparam int unsigned SEL_W = $clog2(NP);
  localparam int unsigned NBUS  = 3;
  localparam int unsigned NPAIR = 2;

  localparam int unsigned IDX_N = 0;
  localparam int unsigned IDX_E = 1;
  localparam int unsigned IDX_S = 2;
  localparam int unsigned IDX_W = 3;
  localparam int unsigned IDX_L = 4;

  localparam int unsigned BUS_H = 0;
  localparam int unsigned BUS_V = 1;
  localparam int unsigned BUS_L = 2;

  // shared buses: first member preferred after reset
  localparam int unsigned PAIR_A [NPAIR] = '{IDX_E, IDX_N};
  localparam int unsigned PAIR_B [NPAIR] = '{IDX_W, IDX_S};

  function automatic logic is_x_port(input logic [SEL_W-1:0] p);
    return (p == SEL_W'(IDX_E)) || (p == SEL_W'(IDX_W));
  endfunction

  function automatic logic is_y_port(input logic [SEL_W-1:0] p);
    return (p == SEL_W'(IDX_N)) || (p == SEL_W'(IDX_S));
  endfunction
endpackage

// File: rtl/noc_xbar_out_mux.sv
module noc_xbar_out_mux
  import noc_xbar_pkg::*;
#(
  parameter int unsigned FLIT_W = 128
) (
  input  logic [NP-1:0][FLIT_W-1:0] flit_i,
  input  logic [NP-1:0]             valid_i,
  input  logic                      req_i,
  input  logic [SEL_W-1:0]          sel_i,
  output logic [FLIT_W-1:0]         flit_o,
  output logic                      valid_o
);
  logic src_vld;

  always_comb begin
    flit_o  = '0;
    src_vld = 1'b0;
    for (int i = 0; i < int'(NP); i++) begin
      if (sel_i == SEL_W'(i)) begin
        flit_o  = flit_i[i];
        src_vld = valid_i[i];
      end
    end
  end

  assign valid_o = req_i & src_vld;
endmodule

// File: rtl/noc_xbar_rr2.sv
module noc_xbar_rr2 (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,
  output logic [1:0] gnt_o
);
  logic pref_q; // 0: member 0 preferred

  assign gnt_o[0] = req_i[0] & (~req_i[1] | ~pref_q);
  assign gnt_o[1] = req_i[1] & (~req_i[0] |  pref_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pref_q <= 1'b0;
    else if (gnt_o[0]) pref_q <= 1'b1;
    else if (gnt_o[1]) pref_q <= 1'b0;
  end
endmodule

// File: rtl/noc_xbar_bp_ctl.sv
module noc_xbar_bp_ctl
  import noc_xbar_pkg::*;
#(
  parameter int unsigned FLIT_W = 128
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NP-1:0][FLIT_W-1:0]    flit_i,
  input  logic [NP-1:0]                valid_i,
  input  logic [NP-1:0]                out_req_i,
  input  logic [NP-1:0][SEL_W-1:0]     out_sel_i,
  input  logic [NP-1:0]                mux_fault_i,
  output logic [NBUS-1:0]              bus_vld_o,
  output logic [NBUS-1:0][SEL_W-1:0]   bus_tgt_o,
  output logic [NBUS-1:0][FLIT_W-1:0]  bus_flit_o,
  output logic [NP-1:0]                stall_o,
  output logic [NP-1:0]                illegal_o
);
  logic [NP-1:0]            want;
  logic [NP-1:0]            legal;
  logic [NP-1:0][SEL_W-1:0] tgt;
  logic [1:0]               gnt [NPAIR];

  // which faulty output, if any, pulls each input through a bypass
  always_comb begin
    for (int s = 0; s < int'(NP); s++) begin
      want[s] = 1'b0;
      tgt[s]  = '0;
      for (int o = 0; o < int'(NP); o++) begin
        if (out_req_i[o] && mux_fault_i[o] && out_sel_i[o] == SEL_W'(s)) begin
          want[s] = valid_i[s];
          tgt[s]  = SEL_W'(o);
        end
      end
    end
  end

  always_comb begin
    for (int s = 0; s < int'(NP); s++) begin
      illegal_o[s] = want[s] && is_y_port(SEL_W'(s)) && is_x_port(tgt[s]);
      legal[s]     = want[s] & ~illegal_o[s];
    end
  end

  for (genvar b = 0; b < int'(NPAIR); b++) begin : g_pair
    noc_xbar_rr2 u_rr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  ({legal[PAIR_B[b]], legal[PAIR_A[b]]}),
      .gnt_o  (gnt[b])
    );
    assign bus_vld_o[b]  = |gnt[b];
    assign bus_tgt_o[b]  = gnt[b][1] ? tgt[PAIR_B[b]]    : tgt[PAIR_A[b]];
    assign bus_flit_o[b] = gnt[b][1] ? flit_i[PAIR_B[b]] : flit_i[PAIR_A[b]];
  end

  assign bus_vld_o[BUS_L]  = legal[IDX_L];
  assign bus_tgt_o[BUS_L]  = tgt[IDX_L];
  assign bus_flit_o[BUS_L] = flit_i[IDX_L];

  always_comb begin
    stall_o = '0;
    for (int b = 0; b < int'(NPAIR); b++) begin
      stall_o[PAIR_A[b]] = legal[PAIR_A[b]] & ~gnt[b][0];
      stall_o[PAIR_B[b]] = legal[PAIR_B[b]] & ~gnt[b][1];
    end
  end
endmodule

// File: rtl/noc_xbar_bypass.sv
module noc_xbar_bypass
  import noc_xbar_pkg::*;
#(
  parameter int unsigned FLIT_W = 128
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NP-1:0][FLIT_W-1:0] flit_i,
  input  logic [NP-1:0]             valid_i,
  input  logic [NP-1:0]             out_req_i,
  input  logic [NP-1:0][SEL_W-1:0]  out_sel_i,
  input  logic [NP-1:0]             mux_fault_i,
  output logic [NP-1:0][FLIT_W-1:0] flit_o,
  output logic [NP-1:0]             valid_o,
  output logic [NP-1:0]             stall_o,
  output logic [NP-1:0]             illegal_o
);
  logic [NBUS-1:0]             bus_vld;
  logic [NBUS-1:0][SEL_W-1:0]  bus_tgt;
  logic [NBUS-1:0][FLIT_W-1:0] bus_flit;

  noc_xbar_bp_ctl #(.FLIT_W(FLIT_W)) u_bp_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flit_i      (flit_i),
    .valid_i     (valid_i),
    .out_req_i   (out_req_i),
    .out_sel_i   (out_sel_i),
    .mux_fault_i (mux_fault_i),
    .bus_vld_o   (bus_vld),
    .bus_tgt_o   (bus_tgt),
    .bus_flit_o  (bus_flit),
    .stall_o     (stall_o),
    .illegal_o   (illegal_o)
  );

  for (genvar o = 0; o < int'(NP); o++) begin : g_out
    // X-axis outputs have no tap on the vertical bus
    localparam logic [NBUS-1:0] BUS_MASK =
      ((o == int'(IDX_E)) || (o == int'(IDX_W))) ? NBUS'(3'b101) : NBUS'(3'b111);

    logic [FLIT_W-1:0] mux_flit;
    logic              mux_vld;
    logic [FLIT_W-1:0] bp_flit;
    logic              bp_vld;

    noc_xbar_out_mux #(.FLIT_W(FLIT_W)) u_mux (
      .flit_i  (flit_i),
      .valid_i (valid_i),
      .req_i   (out_req_i[o]),
      .sel_i   (out_sel_i[o]),
      .flit_o  (mux_flit),
      .valid_o (mux_vld)
    );

    always_comb begin
      bp_vld  = 1'b0;
      bp_flit = '0;
      for (int b = 0; b < int'(NBUS); b++) begin
        if (BUS_MASK[b] && bus_vld[b] && bus_tgt[b] == SEL_W'(o)) begin
          bp_vld  = 1'b1;
          bp_flit = bus_flit[b];
        end
      end
    end

    assign valid_o[o] = mux_fault_i[o] ? bp_vld  : mux_vld;
    assign flit_o[o]  = mux_fault_i[o] ? bp_flit : mux_flit;
  end
endmodule

// File: rtl/noc_xbar_bypass_chk.sv
module noc_xbar_bypass_chk
  import noc_xbar_pkg::*;
#(
  parameter int unsigned FLIT_W = 128
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NP-1:0][FLIT_W-1:0] flit_i,
  input logic [NP-1:0]             valid_i,
  input logic [NP-1:0]             out_req_i,
  input logic [NP-1:0][SEL_W-1:0]  out_sel_i,
  input logic [NP-1:0]             mux_fault_i,
  input logic [NP-1:0][FLIT_W-1:0] flit_o,
  input logic [NP-1:0]             valid_o,
  input logic [NP-1:0]             stall_o,
  input logic [NP-1:0]             illegal_o
);
  for (genvar o = 0; o < int'(NP); o++) begin : g_o
    AST_HEALTHY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_req_i[o] && !mux_fault_i[o] && out_sel_i[o] < SEL_W'(NP) && valid_i[out_sel_i[o]])
      |-> (valid_o[o] && flit_o[o] == flit_i[out_sel_i[o]])); // R2
    AST_IDLE_OUT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_req_i[o] |-> !valid_o[o]); // R8
    if (o == int'(IDX_E) || o == int'(IDX_W)) begin : g_x
      AST_NO_Y_TO_X: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mux_fault_i[o] && valid_o[o]) |-> !is_y_port(out_sel_i[o])); // R5
    end
    if (o != int'(IDX_L)) begin : g_sh
      AST_RR_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o[o] |=> !stall_o[o]); // R7
    end
    AST_ILLEGAL_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o[o] |-> !stall_o[o]); // R5
  end

  AST_BUS_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(valid_o & mux_fault_i) <= 3); // R4
  AST_ONE_LOSER_H: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stall_o[IDX_E] && stall_o[IDX_W])); // R6
  AST_ONE_LOSER_V: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stall_o[IDX_N] && stall_o[IDX_S])); // R6
  AST_LOCAL_NEVER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o[IDX_L]); // R6
endmodule

bind noc_xbar_bypass noc_xbar_bypass_chk #(.FLIT_W(FLIT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flit_i      (flit_i),
  .valid_i     (valid_i),
  .out_req_i   (out_req_i),
  .out_sel_i   (out_sel_i),
  .mux_fault_i (mux_fault_i),
  .flit_o      (flit_o),
  .valid_o     (valid_o),
  .stall_o     (stall_o),
  .illegal_o   (illegal_o)
);

// File: tb/noc_xbar_bypass_tb.sv
module noc_xbar_bypass_tb;
  localparam int W = 128;
  localparam int N = 0, E = 1, S = 2, Wp = 3, L = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [4:0][W-1:0] flit_i;
  logic [4:0]        valid_i, out_req_i, mux_fault_i;
  logic [4:0][2:0]   out_sel_i;
  logic [4:0][W-1:0] flit_o;
  logic [4:0]        valid_o, stall_o, illegal_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  noc_xbar_bypass #(.FLIT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .flit_i(flit_i), .valid_i(valid_i),
    .out_req_i(out_req_i), .out_sel_i(out_sel_i), .mux_fault_i(mux_fault_i),
    .flit_o(flit_o), .valid_o(valid_o), .stall_o(stall_o), .illegal_o(illegal_o)
  );

  function automatic logic [W-1:0] pat(input int s);
    return {4{32'h1111_1111 * 32'(s + 1)}} ^ {W{1'b0}} | W'(s);
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    for (int s = 0; s < 5; s++) flit_i[s] = pat(s);
    valid_i = 5'b11111; out_req_i = '0; mux_fault_i = '0; out_sel_i = '0;
  endtask

  task automatic route(input int o, input int s);
    out_req_i[o] = 1'b1; out_sel_i[o] = 3'(s);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; idle();
    #1;
    chk("R9 valid in reset", W'(valid_o), '0);
    chk("R9 stall in reset", W'(stall_o), '0);
    chk("R9 illegal in reset", W'(illegal_o), '0);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic t_healthy();
    @(negedge clk); idle();
    route(N, S); route(E, Wp); route(S, N); route(Wp, E); route(L, L);
    #1;
    chk("R2 all valid", W'(valid_o), W'(5'b11111));
    chk("R2 N<-S", flit_o[N], pat(S));
    chk("R2 E<-W", flit_o[E], pat(Wp));
    chk("R1 S<-N", flit_o[S], pat(N));
    chk("R2 L<-L", flit_o[L], pat(L));
    @(negedge clk); idle();
    route(N, 5); route(E, Wp); valid_i[Wp] = 1'b0; mux_fault_i[S] = 1'b1;
    #1;
    chk("R8 idle/invalid/oor outputs", W'(valid_o), '0);
  endtask

  task automatic t_fault_single();
    @(negedge clk); idle();
    mux_fault_i = 5'b00111;
    route(E, Wp); route(N, S); route(S, L); route(L, E);
    #1;
    chk("R3 valid map", W'(valid_o), W'(5'b10111));
    chk("R3 E<-W horizontal", flit_o[E], pat(Wp));
    chk("R3 N<-S vertical", flit_o[N], pat(S));
    chk("R3 S<-L local", flit_o[S], pat(L));
    chk("R3 healthy L<-E", flit_o[L], pat(E));
    chk("R3 no stall", W'(stall_o), '0);
  endtask

  task automatic t_all_fault();
    @(negedge clk); idle();
    mux_fault_i = 5'b11111;
    route(N, S); route(Wp, E); route(E, L);
    #1;
    chk("R4 three flits", W'(valid_o), W'(5'b01011));
    chk("R4 N<-S", flit_o[N], pat(S));
    chk("R4 W<-E", flit_o[Wp], pat(E));
    chk("R4 E<-L", flit_o[E], pat(L));
  endtask

  task automatic t_illegal();
    @(negedge clk); idle();
    mux_fault_i[E] = 1'b1;
    route(E, N); route(L, L);
    #1;
    chk("R5 illegal flag", W'(illegal_o), W'(5'b00001));
    chk("R5 E dropped, L ok", W'(valid_o), W'(5'b10000));
    chk("R5 no stall", W'(stall_o), '0);
  endtask

  task automatic t_contend_h();
    do_reset();
    @(negedge clk); idle(); mux_fault_i[N] = 1'b1; mux_fault_i[S] = 1'b1;
    route(N, E); route(S, Wp);
    #1;
    chk("R7 E first after reset", W'(valid_o), W'(5'b00001));
    chk("R6 E wins flit", flit_o[N], pat(E));
    chk("R6 W stalls", W'(stall_o), W'(5'b01000));
    @(negedge clk); #1;
    chk("R7 W wins next", W'(valid_o), W'(5'b00100));
    chk("R7 W flit", flit_o[S], pat(Wp));
    chk("R6 E stalls", W'(stall_o), W'(5'b00010));
    @(negedge clk); out_req_i[S] = 1'b0;
    #1;
    chk("R7 lone E served", W'(valid_o), W'(5'b00001));
    chk("R7 lone no stall", W'(stall_o), '0);
    @(negedge clk); route(S, Wp);
    #1;
    chk("R7 W preferred after E", W'(stall_o), W'(5'b00010));
  endtask

  task automatic t_contend_v();
    do_reset();
    @(negedge clk); idle(); mux_fault_i[N] = 1'b1; mux_fault_i[L] = 1'b1;
    route(N, S); route(L, N);
    #1;
    chk("R7 N first after reset", W'(valid_o), W'(5'b10000));
    chk("R6 N flit on L", flit_o[L], pat(N));
    chk("R6 S stalls", W'(stall_o), W'(5'b00100));
    @(negedge clk); #1;
    chk("R7 S wins next", W'(valid_o), W'(5'b00001));
    chk("R7 S flit on N", flit_o[N], pat(S));
    chk("R6 N stalls", W'(stall_o), W'(5'b00001));
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    #1;
    chk("R9 valid in reset", W'(valid_o), '0);
    @(negedge clk); rst_ni = 1'b1;
    t_healthy();
    t_fault_single();
    t_all_fault();
    t_illegal();
    t_contend_h();
    t_contend_v();
    @(negedge clk); idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule